// File: doc/BRIEF.md
# SMBus Host Transaction Sequencer

This block is the command layer of an SMBus host controller. A client presents one transaction request at a time: a transaction code, a 7-bit target address, a command byte, a packed write-data vector and a block length. When the block is idle, a one-cycle `start` pulse captures the request. The block then turns it into an ordered series of bus primitives for a byte-level link engine underneath it. The primitives are START, repeated START, write byte with the acknowledge sampled, read byte with ACK or NACK returned, and STOP. Bit timing, electrical drive, arbitration and packet error checking belong to the link engine or to other blocks.

The link engine sees one primitive at a time. `lk_req` stays high and `lk_op`, `lk_wbyte` and `lk_rd_ack` stay constant until the engine pulses `lk_done`. On a write byte, the engine reports a missing device acknowledge on `lk_nack`, in the same cycle as `lk_done`. On a read byte, it returns the data on `lk_rbyte`.

Bytes read from the device collect in a small result buffer exposed as `rdata`, byte 0 in the low eight bits. `rcount` gives the number of valid bytes. A missing acknowledge or an unusable block count from the device ends the transaction early with a STOP and raises an error flag. In every case a one-cycle `done` pulse marks the end of the transaction.

Top module: `smb_host_seq`

## Requirements
- R1: After reset, `busy`, `done`, `lk_req`, `err_nack` and `err_badcnt` are all 0.
- R2: Quick write (txn_type 0) issues START, then a write of `{addr, wdata[0]}`, then STOP.
- R3: Send byte (txn_type 1) issues START, write `{addr,0}`, write `cmd`, STOP. Receive byte (txn_type 2) issues START, write `{addr,1}`, one read with NACK, STOP, and leaves the byte in `rdata[7:0]` with `rcount` = 1.
- R4: Write byte data (txn_type 3) and write word (txn_type 5) issue START, write `{addr,0}`, write `cmd`, then the data bytes low first (wdata byte 0, then byte 1), then STOP.
- R5: Read byte data (4), read word (6) and process call (7) first perform their write part: address, command, and for process call data bytes 0 and 1. They then issue a repeated START, write `{addr,1}`, and read 1 or 2 bytes. Every read byte is acknowledged except the last, which gets a NACK before the STOP. The result is stored low byte first in `rdata`, and `rcount` equals the number of bytes read.
- R6: Block write (8) and the write part of block process call (10) send `cmd`, then a count byte equal to `wcount`, then `wcount` bytes starting at wdata byte 0.
- R7: Block read (9) and the read part of block process call take the first byte returned as the count and acknowledge it. They then read that many bytes with the last NACKed, store them in `rdata` from byte 0, and set `rcount` to the count.
- R8: A returned count is invalid if it is 0, or if it exceeds 32 for block read or 31 for block process call. On an invalid count, `err_badcnt` is set, exactly one more byte is read with NACK, and a STOP follows.
- R9: If the device does not acknowledge a written byte, the next primitive is STOP and `err_nack` is set. `err_idx` then holds the zero-based position of that byte among all bytes the host wrote in the transaction. The first address byte is position 0, and the address byte after the repeated START is counted too.
- R10: `done` is high for exactly one cycle, the cycle after the link engine completes the STOP. `busy` is low in that same cycle.
- R11: A `start` pulse while `busy` is high has no effect on the transaction in progress.
- R12: `lk_op` codes are START=0, repeated START=1, write=2, read=3, STOP=4. While `lk_req` is high and `lk_done` is low, `lk_op`, `lk_wbyte` and `lk_rd_ack` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse, taken only when idle |
| txn_type | input | 4 | Transaction code, 0 to 10 |
| addr | input | 7 | Target address |
| cmd | input | 8 | Command byte (the data byte for send byte) |
| wdata | input | MAX_BLK*8 | Write bytes, byte k at bits 8k+7:8k |
| wcount | input | $clog2(MAX_BLK+1) | Block write length |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| err_nack | output | 1 | A written byte was not acknowledged |
| err_badcnt | output | 1 | The device returned an invalid block count |
| err_idx | output | $clog2(MAX_BLK+5) | Position of the byte that was not acknowledged |
| rdata | output | MAX_BLK*8 | Read result buffer |
| rcount | output | $clog2(MAX_BLK+1) | Number of valid result bytes |
| lk_req | output | 1 | A primitive is pending for the link engine |
| lk_op | output | 3 | Primitive code |
| lk_wbyte | output | 8 | Byte to transmit |
| lk_rd_ack | output | 1 | 1: ACK the read byte, 0: NACK it |
| lk_done | input | 1 | Link engine completed the primitive |
| lk_nack | input | 1 | Device did not acknowledge the written byte |
| lk_rbyte | input | 8 | Byte received by the link engine |

## Verification
The hardest case to reach from the ports is an abort in the middle of a long transaction. One example is a NACK on the address byte after the repeated START of a block process call. Another is a block count that is legal for block read but one too large for block process call. Only a device model that counts the bytes of each transaction can place such a fault at an exact point. The bench link model counts every written byte from the START and withholds the acknowledge at a chosen position. It returns a chosen count as the first read byte. Directed cases cover count values 0, 31, 32 and 33 and NACKs at positions 0, 2 and inside the data. Random requests then move the fault position over all transaction codes.

// File: rtl/smb_seq_pkg.sv
package smb_seq_pkg;

  typedef enum logic [2:0] {
    OP_START  = 3'd0,
    OP_RSTART = 3'd1,
    OP_WR     = 3'd2,
    OP_RD     = 3'd3,
    OP_STOP   = 3'd4
  } lk_op_e;

  typedef enum logic [3:0] {
    T_QUICK = 4'd0, T_SEND = 4'd1, T_RECV = 4'd2, T_WRB = 4'd3,
    T_RDB   = 4'd4, T_WRW  = 4'd5, T_RDW  = 4'd6, T_PCALL = 4'd7,
    T_BWR   = 4'd8, T_BRD  = 4'd9, T_BPC  = 4'd10
  } txn_e;

  typedef enum logic [3:0] {
    P_IDLE, P_START, P_ADDR, P_CMD, P_WCNT, P_WDAT,
    P_RSTART, P_RADDR, P_RCNT, P_RDAT, P_FLUSH, P_STOP
  } phase_e;

  // Shape of one transaction type.
  typedef struct packed {
    logic       quick;     // address only, data in the direction bit
    logic       wr_first;  // first address byte carries the write bit
    logic       has_cmd;
    logic       wr_blk;    // count byte plus block of write data
    logic [1:0] wr_n;      // fixed number of write data bytes
    logic       rd;
    logic       rd_blk;    // count-prefixed read
    logic [1:0] rd_n;      // fixed number of read bytes
  } prof_t;

  function automatic prof_t txn_profile(logic [3:0] t);
    prof_t p;
    p = '{quick: 1'b0, wr_first: 1'b1, has_cmd: 1'b1, wr_blk: 1'b0,
          wr_n: 2'd0, rd: 1'b0, rd_blk: 1'b0, rd_n: 2'd0};
    case (t)
      T_SEND:  ;
      T_RECV:  begin p.wr_first = 1'b0; p.has_cmd = 1'b0; p.rd = 1'b1; p.rd_n = 2'd1; end
      T_WRB:   p.wr_n = 2'd1;
      T_RDB:   begin p.rd = 1'b1; p.rd_n = 2'd1; end
      T_WRW:   p.wr_n = 2'd2;
      T_RDW:   begin p.rd = 1'b1; p.rd_n = 2'd2; end
      T_PCALL: begin p.wr_n = 2'd2; p.rd = 1'b1; p.rd_n = 2'd2; end
      T_BWR:   p.wr_blk = 1'b1;
      T_BRD:   begin p.rd = 1'b1; p.rd_blk = 1'b1; end
      T_BPC:   begin p.wr_blk = 1'b1; p.rd = 1'b1; p.rd_blk = 1'b1; end
      default: begin p.quick = 1'b1; p.has_cmd = 1'b0; end
    endcase
    return p;
  endfunction

  function automatic logic count_ok(logic [7:0] c, int unsigned lim);
    return (c != 8'd0) && (int'(c) <= int'(lim));
  endfunction

  function automatic logic [2:0] op_of(phase_e ph);
    case (ph)
      P_START:  return OP_START;
      P_RSTART: return OP_RSTART;
      P_ADDR, P_CMD, P_WCNT, P_WDAT, P_RADDR: return OP_WR;
      P_RCNT, P_RDAT, P_FLUSH: return OP_RD;
      default:  return OP_STOP;
    endcase
  endfunction

endpackage

// File: rtl/smb_seq_decode.sv
module smb_seq_decode
  import smb_seq_pkg::*;
(
  input  logic [3:0] txn,
  output prof_t      prof
);
  assign prof = txn_profile(txn);
endmodule

// File: rtl/smb_seq_txsel.sv
module smb_seq_txsel
  import smb_seq_pkg::*;
#(
  parameter int MAX_BLK = 32,
  localparam int CW = $clog2(MAX_BLK + 1)
) (
  input  phase_e              ph,
  input  logic [6:0]          addr,
  input  logic                dir_bit,
  input  logic [7:0]          cmd,
  input  logic [CW-1:0]       wcount,
  input  logic [MAX_BLK*8-1:0] wdata,
  input  logic [CW-1:0]       widx,
  output logic [7:0]          wbyte
);
  always_comb begin
    case (ph)
      P_ADDR:  wbyte = {addr, dir_bit};
      P_RADDR: wbyte = {addr, 1'b1};
      P_CMD:   wbyte = cmd;
      P_WCNT:  wbyte = 8'(wcount);
      P_WDAT:  wbyte = wdata[widx*8 +: 8];
      default: wbyte = 8'h00;
    endcase
  end
endmodule

// File: rtl/smb_seq_rxbuf.sv
module smb_seq_rxbuf #(
  parameter int MAX_BLK = 32,
  localparam int CW = $clog2(MAX_BLK + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [CW-1:0]        idx,
  input  logic [7:0]           din,
  output logic [MAX_BLK*8-1:0] rdata
);
  for (genvar s = 0; s < MAX_BLK; s++) begin : g_slot
    logic [7:0] slot_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        slot_q <= 8'h00;
      else if (we && idx == CW'(s))      slot_q <= din;
    end
    assign rdata[s*8 +: 8] = slot_q;
  end
endmodule

// File: rtl/smb_host_seq.sv
module smb_host_seq
  import smb_seq_pkg::*;
#(
  parameter int MAX_BLK = 32,
  localparam int CW = $clog2(MAX_BLK + 1),
  localparam int BW = $clog2(MAX_BLK + 5)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [3:0]           txn_type,
  input  logic [6:0]           addr,
  input  logic [7:0]           cmd,
  input  logic [MAX_BLK*8-1:0] wdata,
  input  logic [CW-1:0]        wcount,
  output logic                 busy,
  output logic                 done,
  output logic                 err_nack,
  output logic                 err_badcnt,
  output logic [BW-1:0]        err_idx,
  output logic [MAX_BLK*8-1:0] rdata,
  output logic [CW-1:0]        rcount,
  output logic                 lk_req,
  output logic [2:0]           lk_op,
  output logic [7:0]           lk_wbyte,
  output logic                 lk_rd_ack,
  input  logic                 lk_done,
  input  logic                 lk_nack,
  input  logic [7:0]           lk_rbyte
);
  phase_e               ph, nx;
  logic [3:0]           t_q;
  logic [6:0]           a_q;
  logic [7:0]           c_q;
  logic [MAX_BLK*8-1:0] wd_q;
  logic [CW-1:0]        wc_q, widx, ridx, rtot;
  logic [BW-1:0]        bidx;
  prof_t                prof;

  // Named internal events, also observed by the checker.
  logic op_fin, is_wr_op, wr_nack, cnt_bad, last_rd, last_wr, accept;
  logic [CW-1:0] wr_tot;
  int unsigned   rd_lim;
  phase_e        post_wr;

  smb_seq_decode u_dec (.txn(t_q), .prof(prof));

  assign accept   = start && (ph == P_IDLE);
  assign op_fin   = lk_req && lk_done;
  assign is_wr_op = (ph == P_ADDR) || (ph == P_CMD) || (ph == P_WCNT) ||
                    (ph == P_WDAT) || (ph == P_RADDR);
  assign wr_nack  = op_fin && is_wr_op && lk_nack;
  assign rd_lim   = (t_q == T_BPC) ? MAX_BLK - 1 : MAX_BLK;
  assign cnt_bad  = op_fin && (ph == P_RCNT) && !count_ok(lk_rbyte, rd_lim);
  assign wr_tot   = prof.wr_blk ? wc_q : CW'(prof.wr_n);
  assign last_wr  = (widx == wr_tot - CW'(1));
  assign last_rd  = (ridx == rtot - CW'(1));
  assign post_wr  = prof.rd ? P_RSTART : P_STOP;

  always_comb begin
    nx = ph;
    if (ph == P_IDLE) begin
      if (start) nx = P_START;
    end else if (ph == P_STOP) begin
      if (lk_done) nx = P_IDLE;
    end else if (lk_done) begin
      if (is_wr_op && lk_nack) nx = P_STOP;
      else begin
        case (ph)
          P_START:  nx = P_ADDR;
          P_ADDR: begin
            if (prof.quick)          nx = P_STOP;
            else if (!prof.wr_first) nx = prof.rd_blk ? P_RCNT : P_RDAT;
            else if (prof.has_cmd)   nx = P_CMD;
            else                     nx = P_STOP;
          end
          P_CMD:    nx = prof.wr_blk ? P_WCNT : ((wr_tot != '0) ? P_WDAT : post_wr);
          P_WCNT:   nx = (wr_tot != '0) ? P_WDAT : post_wr;
          P_WDAT:   nx = last_wr ? post_wr : P_WDAT;
          P_RSTART: nx = P_RADDR;
          P_RADDR:  nx = prof.rd_blk ? P_RCNT : P_RDAT;
          P_RCNT:   nx = count_ok(lk_rbyte, rd_lim) ? P_RDAT : P_FLUSH;
          P_RDAT:   nx = last_rd ? P_STOP : P_RDAT;
          default:  nx = P_STOP;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= P_IDLE; t_q <= '0; a_q <= '0; c_q <= '0; wd_q <= '0; wc_q <= '0;
      widx <= '0; ridx <= '0; rtot <= '0; bidx <= '0;
      err_nack <= 1'b0; err_badcnt <= 1'b0; err_idx <= '0; done <= 1'b0;
    end else begin
      ph   <= nx;
      done <= op_fin && (ph == P_STOP);
      if (accept) begin
        t_q <= txn_type; a_q <= addr; c_q <= cmd; wd_q <= wdata; wc_q <= wcount;
        widx <= '0; ridx <= '0; bidx <= '0;
        rtot <= CW'(txn_profile(txn_type).rd_n);
        err_nack <= 1'b0; err_badcnt <= 1'b0; err_idx <= '0;
      end else if (op_fin) begin
        if (is_wr_op)      bidx <= bidx + BW'(1);
        if (ph == P_WDAT)  widx <= widx + CW'(1);
        if (ph == P_RDAT)  ridx <= ridx + CW'(1);
        if (ph == P_RCNT && !cnt_bad) rtot <= lk_rbyte[CW-1:0];
        if (wr_nack) begin err_nack <= 1'b1; err_idx <= bidx; end
        if (cnt_bad) err_badcnt <= 1'b1;
      end
    end
  end

  smb_seq_txsel #(.MAX_BLK(MAX_BLK)) u_tx (
    .ph(ph), .addr(a_q), .dir_bit(prof.quick ? wd_q[0] : !prof.wr_first),
    .cmd(c_q), .wcount(wc_q), .wdata(wd_q), .widx(widx), .wbyte(lk_wbyte)
  );

  smb_seq_rxbuf #(.MAX_BLK(MAX_BLK)) u_rx (
    .clk(clk), .rst_n(rst_n), .we(op_fin && ph == P_RDAT),
    .idx(ridx), .din(lk_rbyte), .rdata(rdata)
  );

  assign busy      = (ph != P_IDLE);
  assign lk_req    = (ph != P_IDLE);
  assign lk_op     = op_of(ph);
  assign lk_rd_ack = (ph == P_RCNT) || (ph == P_RDAT && !last_rd);
  assign rcount    = rtot;
endmodule

// File: rtl/smb_host_seq_chk.sv
module smb_host_seq_chk
  import smb_seq_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       done,
  input logic       err_nack,
  input logic       err_badcnt,
  input logic       lk_req,
  input logic [2:0] lk_op,
  input logic [7:0] lk_wbyte,
  input logic       lk_rd_ack,
  input logic       lk_done,
  input logic       wr_nack,
  input logic       cnt_bad
);
  assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_req && !lk_done) |=> (lk_req && $stable(lk_op) && $stable(lk_wbyte) && $stable(lk_rd_ack)));

  assert_nack_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_nack |=> (lk_req && lk_op == OP_STOP && err_nack));

  assert_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_bad |=> (lk_req && lk_op == OP_RD && !lk_rd_ack && err_badcnt));

  assert_last_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_req && lk_done && lk_op == OP_RD && !lk_rd_ack) |=> (lk_req && lk_op == OP_STOP));

  assert_rs_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_req && lk_done && lk_op == OP_RSTART) |=> (lk_op == OP_WR && lk_wbyte[0]));

  assert_done_after_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_req && lk_done && lk_op == OP_STOP) |=> (done && !busy));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind smb_host_seq smb_host_seq_chk u_chk (.*);

// File: tb/smb_host_seq_tb.sv
module smb_host_seq_tb;
  localparam int MB = 32;
  localparam int CW = $clog2(MB + 1);
  localparam int BW = $clog2(MB + 5);

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [3:0] txn_type = '0;
  logic [6:0] addr = '0;
  logic [7:0] cmd = '0;
  logic [MB*8-1:0] wdata = '0;
  logic [CW-1:0] wcount = '0;
  logic busy, done, err_nack, err_badcnt, lk_req, lk_rd_ack;
  logic [BW-1:0] err_idx;
  logic [MB*8-1:0] rdata;
  logic [CW-1:0] rcount;
  logic [2:0] lk_op;
  logic [7:0] lk_wbyte;
  logic lk_done = 1'b0, lk_nack = 1'b0;
  logic [7:0] lk_rbyte = '0;

  always #4 clk = ~clk;

  smb_host_seq #(.MAX_BLK(MB)) u_dut (.*);

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // Device model settings and the log of observed primitives {op,ack,byte}.
  bit cur_blk = 0; int nack_at = 99; int dev_cnt = 0;
  logic [11:0] log_q [0:127]; int log_n = 0;
  logic [11:0] exp_q [0:127]; int exp_n = 0;
  int rk = 0, wk = 0;

  function automatic logic [7:0] pat(int k);
    return 8'(8'h3C + 29 * k);
  endfunction

  task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
    end
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 180000);
    n_chk++; n_fail++;
    $display("FAIL R10 watchdog: actual %h expected %h", 0, 1);
    finish_up();
  end

  // Link engine and device model.
  initial begin
    forever begin
      @(negedge clk);
      if (lk_req) begin
        repeat ($urandom_range(0, 2)) @(negedge clk);
        case (lk_op)
          3'd0: begin rk = 0; wk = 0; log_q[log_n] = {3'd0, 9'd0}; end
          3'd2: begin
            log_q[log_n] = {3'd2, 1'b0, lk_wbyte};
            lk_nack = (wk == nack_at); wk++;
          end
          3'd3: begin
            log_q[log_n] = {3'd3, lk_rd_ack, 8'd0};
            lk_rbyte = (cur_blk && rk == 0) ? 8'(dev_cnt) : pat(rk); rk++;
          end
          default: log_q[log_n] = {lk_op, 9'd0};
        endcase
        if (log_n < 127) log_n++;
        lk_done = 1'b1;
        @(negedge clk);
        lk_done = 1'b0; lk_nack = 1'b0;
      end
    end
  end

  // Expected sequence, written from the requirements.
  int e_wi; bit e_ab, e_nack, e_bad; int e_idx, e_rn;

  task automatic push(logic [11:0] v);
    exp_q[exp_n] = v; if (exp_n < 127) exp_n++;
  endtask

  task automatic pwr(logic [7:0] b);
    if (!e_ab) begin
      push({3'd2, 1'b0, b});
      if (e_wi == nack_at) begin e_ab = 1; e_nack = 1; e_idx = e_wi; end
      e_wi++;
    end
  endtask

  task automatic build_exp(int t, logic [6:0] a, logic [7:0] c, int wc, logic [MB*8-1:0] wd, int dcnt);
    bit hc, wb, rd, rb; int wn, rn, lim;
    hc = (t >= 1 && t != 2 && t <= 10);
    wb = (t == 8 || t == 10);
    rd = (t == 2 || t == 4 || t == 6 || t == 7 || t == 9 || t == 10);
    rb = (t == 9 || t == 10);
    wn = wb ? wc : (t == 3) ? 1 : (t == 5 || t == 7) ? 2 : 0;
    rn = (t == 6 || t == 7) ? 2 : 1;
    lim = (t == 10) ? 31 : 32;
    exp_n = 0; e_wi = 0; e_ab = 0; e_nack = 0; e_bad = 0; e_idx = 0; e_rn = 0;
    push({3'd0, 9'd0});
    if (t == 2)       pwr({a, 1'b1});
    else if (t == 0)  pwr({a, wd[0]});
    else              pwr({a, 1'b0});
    if (t != 0) begin
      if (hc) pwr(c);
      if (wb) pwr(8'(wc));
      for (int j = 0; j < wn; j++) pwr(wd[j*8 +: 8]);
      if (!e_ab && rd && t != 2) begin push({3'd1, 9'd0}); pwr({a, 1'b1}); end
      if (!e_ab && rd) begin
        if (rb) begin
          push({3'd3, 1'b1, 8'd0});
          if (dcnt == 0 || dcnt > lim) begin e_bad = 1; push({3'd3, 1'b0, 8'd0}); end
          else rn = dcnt;
        end
        if (!e_bad) begin
          e_rn = rn;
          for (int j = 0; j < rn; j++) push({3'd3, (j != rn - 1), 8'd0});
        end
      end
    end
    push({3'd4, 9'd0});
  endtask

  function automatic string tag_of(int t);
    case (t)
      0: return "R2";
      1, 2: return "R3";
      3, 5: return "R4";
      4, 6, 7: return "R5";
      8, 10: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic run_txn(int t, int wc, int dcnt, int nk, bit poke);
    logic [6:0] a; logic [7:0] c; logic [MB*8-1:0] wd; string tg;
    int w, mi; bit seq_ok; logic [MB*8-1:0] er;
    a = 7'($urandom); c = 8'($urandom);
    for (int k = 0; k < MB / 4; k++) wd[k*32 +: 32] = $urandom;
    cur_blk = (t == 9 || t == 10); dev_cnt = dcnt; nack_at = nk; log_n = 0;
    @(negedge clk);
    txn_type = 4'(t); addr = a; cmd = c; wdata = wd; wcount = CW'(wc); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (3) @(negedge clk);
      txn_type = 4'd9; addr = ~a; cmd = ~c; wdata = ~wd; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    w = 0;
    while (!done && w < 20000) begin @(negedge clk); w++; end
    build_exp(t, a, c, wc, wd, dcnt);
    tg = poke ? "R11" : e_nack ? "R9" : e_bad ? "R8" : tag_of(t);
    chk(done && !busy, "R10", "done with busy low", {busy, done}, 2'b01);
    seq_ok = (log_n == exp_n); mi = 0;
    for (int j = 0; j < exp_n && j < log_n; j++)
      if (seq_ok && log_q[j] != exp_q[j]) begin seq_ok = 0; mi = j; end
      else if (seq_ok) mi = j;
    chk(seq_ok, tg, "primitive sequence", {log_n[15:0], 4'd0, log_q[mi]}, {exp_n[15:0], 4'd0, exp_q[mi]});
    chk(err_nack == e_nack && err_badcnt == e_bad, e_bad ? "R8" : "R9", "error flags",
        {err_nack, err_badcnt}, {e_nack, e_bad});
    if (e_nack) chk(int'(err_idx) == e_idx, "R9", "err_idx", err_idx, e_idx);
    if (!e_nack && !e_bad && e_rn > 0) begin
      er = rdata;
      for (int j = 0; j < e_rn; j++) er[j*8 +: 8] = pat(j + (cur_blk ? 1 : 0));
      chk(rdata == er && int'(rcount) == e_rn, cur_blk ? "R7" : (t == 2 ? "R3" : "R5"),
          "read result", {rcount, rdata[47:0]}, {CW'(e_rn), er[47:0]});
    end
    @(negedge clk);
    chk(!done, "R10", "done single cycle", done, 0);
  endtask

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    chk(!busy && !done && !lk_req && !err_nack && !err_badcnt, "R1", "reset state",
        {busy, done, lk_req, err_nack, err_badcnt}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !lk_req, "R1", "idle after release", {busy, lk_req}, 0);
    // Directed cases.
    run_txn(0, 0, 0, 99, 0);
    run_txn(0, 0, 0, 99, 0);
    run_txn(1, 0, 0, 99, 0);
    run_txn(2, 0, 0, 99, 0);
    run_txn(3, 0, 0, 99, 0);
    run_txn(5, 0, 0, 99, 0);
    run_txn(4, 0, 0, 99, 0);
    run_txn(6, 0, 0, 99, 0);
    run_txn(7, 0, 0, 99, 0);
    run_txn(8, 32, 0, 99, 0);
    run_txn(8, 1, 0, 99, 0);
    run_txn(9, 0, 32, 99, 0);
    run_txn(9, 0, 1, 99, 0);
    run_txn(9, 0, 0, 99, 0);
    run_txn(9, 0, 33, 99, 0);
    run_txn(10, 31, 31, 99, 0);
    run_txn(10, 5, 32, 99, 0);
    run_txn(3, 0, 0, 0, 0);
    run_txn(4, 0, 0, 2, 0);
    run_txn(8, 10, 0, 7, 0);
    run_txn(10, 3, 4, 6, 0);
    run_txn(6, 0, 0, 99, 1);
    // Random requests.
    for (int i = 0; i < 70; i++) begin
      int t, wc, dc, nk, lim;
      t = $urandom_range(0, 10);
      lim = (t == 10) ? 31 : 32;
      wc = $urandom_range(1, lim);
      dc = ($urandom_range(0, 7) == 0) ? (($urandom_range(0, 1) == 0) ? 0 : lim + 1)
                                       : $urandom_range(1, lim);
      nk = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 6) : 99;
      run_txn(t, wc, dc, nk, 0);
    end
    finish_up();
  end
endmodule